// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small 8-bit controller. It takes byte writes from the special-function-register bus and watches two addresses on it. Software cannot start the watchdog by setting a bit. It arms the watchdog by writing a fixed pair of key bytes, in order, to a dedicated key register. Writing the same pair again while the watchdog runs restarts the count, and this is how software refreshes it. A hardware-mode input must be high for the key register to respond at all.

A control register at a second address holds a 3-bit divide exponent and reports the enable state. Once enabled, the block counts machine-cycle ticks. The ticks pass through a power-of-two divider set by the exponent and then drive a CNT_W-bit counter. When the counter wraps, the block drives a one-clock reset request and disarms itself. A double-speed input makes each machine tick worth half a count. A hold input stops the count while it is high.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset, ctrl_q reads 0x00 and rst_req is low.
- R2: With hw_mode high, two consecutive writes to the key register (address 0xA6) of 0x1E and then 0xE1 set the enable flag, ctrl_q bit 0, from the clock edge of the second write. The count starts again from zero at that edge.
- R3: With hw_mode high, every write to the key register replaces the stored previous byte, whatever its value. A non-key byte written between 0x1E and 0xE1 therefore prevents enabling. Writes to other addresses do not affect the stored byte.
- R4: While hw_mode is low, writes to the key register have no effect. They do not enable the watchdog and do not replace the stored previous byte.
- R5: A write to the control register (address 0xA7) loads data bits 7..5 into ctrl_q bits 7..5, the exponent PS. Data bits 4..0 are ignored. ctrl_q bits 4..1 always read 0, and software cannot set or clear bit 0.
- R6: While enabled, with double_speed low, rst_req rises at the clock edge of the (2^CNT_W · 2^PS)-th qualifying tick after the enabling edge. A qualifying tick is a cycle with tick high and hold low.
- R7: rst_req is high for exactly one cycle, and the enable flag clears at the same edge. While the watchdog is disabled, no tick produces rst_req.
- R8: An accepted key sequence while the watchdog is enabled restarts the full timeout from that edge.
- R9: With double_speed high, a timeout needs twice as many qualifying ticks as R6 gives.
- R10: Cycles in which hold is high do not advance the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One machine-cycle tick |
| double_speed | input | 1 | Each tick counts as half a step |
| hold | input | 1 | Pauses counting while high |
| hw_mode | input | 1 | Lets the key register respond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| ctrl_q | output | 8 | Control register: PS in 7..5, enable in 0 |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with CNT_W = 4 and leaves the other parameters at their defaults. A full timeout then takes 16 to 2048 steps for PS 0 to 7, so the bench can run complete expirations at several exponents, with and without double speed, instead of only partial counts. It checks that rst_req lands on the exact qualifying tick under sparse ticks and random hold patterns. It also checks that a refresh pushes the expiry out by a full period, and that broken or gated key sequences leave the enable flag clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic {HALF_FIRST = 1'b0, HALF_SECOND = 1'b1} half_e;
endpackage

// File: rtl/wdt_key_detect.sv
module wdt_key_detect
  import wdt_pkg::*;
#(
  parameter byte_t KEY_ADDR   = 8'hA6,
  parameter byte_t KEY_FIRST  = 8'h1E,
  parameter byte_t KEY_SECOND = 8'hE1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  hw_mode,
  input  logic  wr_en,
  input  byte_t wr_addr,
  input  byte_t wr_data,
  output logic  accept
);
  byte_t last_q;
  logic  key_wr;

  assign key_wr = wr_en && hw_mode && (wr_addr == KEY_ADDR);
  assign accept = key_wr && (wr_data == KEY_SECOND) && (last_q == KEY_FIRST);

  always_ff @(posedge clk) begin
    if (rst)         last_q <= '0;
    else if (key_wr) last_q <= wr_data;
  end
endmodule

// File: rtl/wdt_tick_divider.sv
module wdt_tick_divider
  import wdt_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            run,
  input  logic            double_speed,
  input  logic [PS_W-1:0] ps,
  output logic            step
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  half_e            half_q;
  logic             adv;
  logic             hit;

  assign limit = (PRE_W'(1) << ps) - PRE_W'(1);
  assign hit   = (pre_q >= limit);
  assign adv   = run && (!double_speed || (half_q == HALF_SECOND));
  assign step  = adv && hit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q  <= '0;
      half_q <= HALF_FIRST;
    end else begin
      if (run && double_speed)
        half_q <= (half_q == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
      if (adv)
        pre_q <= hit ? '0 : pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = step && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int    CNT_W      = 14,
  parameter int    PS_W       = 3,
  parameter byte_t KEY_ADDR   = 8'hA6,
  parameter byte_t CTL_ADDR   = 8'hA7,
  parameter byte_t KEY_FIRST  = 8'h1E,
  parameter byte_t KEY_SECOND = 8'hE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       double_speed,
  input  logic       hold,
  input  logic       hw_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output logic       rst_req
);
  localparam int PAD_W = 8 - PS_W - 1;

  logic [PS_W-1:0] ps_q;
  logic            en_q;
  logic            req_q;
  logic            accept;
  logic            step;
  logic            wrap;
  logic            run;

  assign run = en_q && tick && !hold;

  wdt_key_detect #(
    .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk(clk), .rst(rst), .hw_mode(hw_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .accept(accept)
  );

  wdt_tick_divider #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst(rst), .clear(accept), .run(run),
    .double_speed(double_speed), .ps(ps_q), .step(step)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(accept), .step(step), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q  <= '0;
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (wr_en && wr_addr == CTL_ADDR)
        ps_q <= wr_data[7 -: PS_W];
      if (accept) begin
        en_q <= 1'b1;
      end else if (wrap) begin
        en_q  <= 1'b0;
        req_q <= 1'b1;
      end
    end
  end

  assign ctrl_q  = {ps_q, {PAD_W{1'b0}}, en_q};
  assign rst_req = req_q;
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter logic [7:0] KEY_ADDR   = 8'hA6,
  parameter logic [7:0] CTL_ADDR   = 8'hA7,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input logic       clk,
  input logic       rst,
  input logic       hw_mode,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl_q,
  input logic       rst_req
);
  assert_enable_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[0]) |-> $past(wr_en && hw_mode && wr_addr == KEY_ADDR && wr_data == KEY_SECOND));

  assert_ps_only_by_write_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_q[7:5]) |-> $past(wr_en && wr_addr == CTL_ADDR));

  assert_req_from_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(ctrl_q[0]));

  assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_req_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !ctrl_q[0]);
endmodule

bind keyed_watchdog keyed_watchdog_chk #(
  .KEY_ADDR(KEY_ADDR), .CTL_ADDR(CTL_ADDR), .KEY_SECOND(KEY_SECOND)
) u_chk (.*);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int TB_CNT_W = 4;

  logic clk = 1'b0;
  logic rst, tick, double_speed, hold, hw_mode, wr_en;
  logic [7:0] wr_addr, wr_data, ctrl_q;
  logic rst_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.CNT_W(TB_CNT_W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .double_speed(double_speed), .hold(hold),
    .hw_mode(hw_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .rst_req(rst_req)
  );

  function automatic int need_ticks(int ps, bit x2);
    return (1 << TB_CNT_W) * (1 << ps) * (x2 ? 2 : 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit t, bit h, bit we, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    tick = t; hold = h; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tick = 1'b0; hold = 1'b0;
  endtask

  task automatic key_write(logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b1, 8'hA6, d);
  endtask

  task automatic arm();
    key_write(8'h1E);
    key_write(8'hE1);
  endtask

  // Runs from a fresh enable until expiry; checks rst_req on every cycle.
  task automatic run_expiry(int ps, bit x2, int dens, int holdp, string req);
    int need = need_ticks(ps, x2);
    int q = 0;
    bit bad = 0;
    int bad_at = -1;
    double_speed = x2;
    for (int n = 0; n < 400000 && q < need; n++) begin
      bit t = ($urandom % 100) < dens;
      bit h = ($urandom % 100) < holdp;
      cyc(t, h, 1'b0, 8'h00, 8'h00);
      if (t && !h) q++;
      if (rst_req != (q == need)) begin
        if (!bad) bad_at = q;
        bad = 1;
      end
    end
    check(!bad, req, bad_at, need);
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    check(rst_req == 1'b0 && ctrl_q[0] == 1'b0, "R7", {rst_req, ctrl_q[0]}, 0);
    double_speed = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; tick = 0; double_speed = 0; hold = 0; hw_mode = 1;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    check(ctrl_q == 8'h00 && rst_req == 1'b0, "R1", ctrl_q, 0);

    // R4: key register gated by hw_mode
    hw_mode = 0;
    arm();
    check(ctrl_q[0] == 1'b0, "R4", ctrl_q, 0);

    // R3: broken sequence, and a non-key write to another address
    hw_mode = 1;
    key_write(8'h1E); key_write(8'h55); key_write(8'hE1);
    check(ctrl_q[0] == 1'b0, "R3", ctrl_q, 0);
    key_write(8'h1E); cyc(1'b0, 1'b0, 1'b1, 8'h90, 8'h33); key_write(8'hE1);
    check(ctrl_q[0] == 1'b1, "R3", ctrl_q, 1);

    // R1 again via reset, then R4 with gated write between keys
    rst = 1; cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00); rst = 0;
    check(ctrl_q == 8'h00, "R1", ctrl_q, 0);
    key_write(8'h1E);
    hw_mode = 0; key_write(8'h55); hw_mode = 1;
    key_write(8'hE1);
    check(ctrl_q[0] == 1'b1, "R4", ctrl_q, 1);

    // R5: control write, low bits ignored, enable not clearable
    cyc(1'b0, 1'b0, 1'b1, 8'hA7, 8'h1E);
    check(ctrl_q == 8'h01, "R5", ctrl_q, 8'h01);
    rst = 1; cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00); rst = 0;
    cyc(1'b0, 1'b0, 1'b1, 8'hA7, 8'hFF);
    check(ctrl_q == 8'hE0, "R5", ctrl_q, 8'hE0);
    cyc(1'b0, 1'b0, 1'b1, 8'hA7, 8'h1F);
    check(ctrl_q == 8'h00, "R5", ctrl_q, 8'h00);

    // R2 + R6: basic timeout, PS = 0
    arm();
    check(ctrl_q == 8'h01, "R2", ctrl_q, 8'h01);
    run_expiry(0, 1'b0, 100, 0, "R6");

    // R7: disabled watchdog never requests
    begin
      bit seen = 0;
      for (int i = 0; i < 60; i++) begin
        cyc(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        if (rst_req) seen = 1;
      end
      check(!seen && ctrl_q[0] == 1'b0, "R7", seen, 0);
    end

    // R8: refresh after partial count restarts the period
    arm();
    repeat (10) cyc(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    check(rst_req == 1'b0 && ctrl_q[0] == 1'b1, "R8", rst_req, 0);
    arm();
    run_expiry(0, 1'b0, 100, 0, "R8");

    // R6 with PS = 2
    cyc(1'b0, 1'b0, 1'b1, 8'hA7, 8'h40);
    arm();
    run_expiry(2, 1'b0, 100, 0, "R6");

    // R9 double speed
    cyc(1'b0, 1'b0, 1'b1, 8'hA7, 8'h20);
    arm();
    run_expiry(1, 1'b1, 100, 0, "R9");

    // R10 hold
    cyc(1'b0, 1'b0, 1'b1, 8'hA7, 8'h00);
    arm();
    run_expiry(0, 1'b0, 100, 50, "R10");

    // Random mixes (R6, R9, R10)
    for (int k = 0; k < 6; k++) begin
      int ps = $urandom % 4;
      bit x2 = $urandom % 2;
      int dens = 30 + ($urandom % 71);
      int hp = $urandom % 31;
      cyc(1'b0, 1'b0, 1'b1, 8'hA7, 8'(ps << 5));
      arm();
      run_expiry(ps, x2, dens, hp, x2 ? "R9" : "R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule